// File: doc/BRIEF.md
# Job Slot Staging and Command Controller

This block holds the register state of one job slot in a job-dispatch engine. Software writes the description of the next job into a set of staging registers through a simple 32-bit write port: a 64-bit chain head pointer, a 64-bit core affinity mask, a configuration word and a staged command word. Storing the start code into the staged command word launches the job. On the clock edge after that store, the staged values move into the active registers and the status becomes active. The staged head and the staged command are then cleared, so the next job can be prepared at once.

A separate immediate-command register accepts soft and hard stops. Two stop variants are qualified by a job-chain flag in the active configuration word. Any attempt to start a job through the immediate-command register is refused and recorded in a sticky error flag. A job ends in one of two ways. With `AUTO_FINISH` set, it ends on the edge after activation. Otherwise it ends when an external execution model reports completion or a fault. At job exit the block writes the exit status and sends a one-cycle done or failed pulse, tagged with the slot number, to job control. All registers can be read through a combinational read port.

Top module: `job_slot_ctrl`

## Requirements
- R1: After reset every readable register reads zero, including the status register (idle code 0x00), and `next_start_o`, `job_done_o`, `job_fail_o` and `job_slot_o` are low.
- R2: Six staging registers are writable and read back what was written: head low/high at offsets 16/17, affinity low/high at 18/19, config at 20 and staged command at 21. A write to any other offset changes no readable register. The active head low/high (0/1), tail low/high (2/3), affinity low/high (4/5), config (6), status (7) and error flag (9) are read-only.
- R3: Storing a value other than 1 (start) in the staged command is kept and launches nothing. `next_start_o` is high exactly while the staged command holds 1.
- R4: On the edge after the staged command stores 1, the staged head is copied into both the active head and the active tail, the staged affinity and config are copied to the active ones, and the status becomes active (0x08).
- R5: On that launch edge the staged head halves and the staged command are cleared to zero. The staged affinity and staged config keep their values.
- R6: With `AUTO_FINISH` set, the status becomes done (0x01) on the edge after activation, and `job_done_o` is high for exactly one cycle. `job_slot_o` carries `SLOT_ID` during a done or failed pulse and is zero otherwise.
- R7: With `AUTO_FINISH` clear, a running job ends when `exec_done_i` is high at an edge. With `exec_fault_i` low the status becomes done (0x01) and `job_done_o` pulses. With `exec_fault_i` high the status becomes the job-fault code (0x40, class field bits 7:6 = 01) and `job_fail_o` pulses instead.
- R8: A soft stop (2) or hard stop (3) written to the command register (offset 8) while a job runs ends the job on the following edge. The status becomes done and `job_done_o` pulses, even if `exec_done_i` with `exec_fault_i` arrives in that same cycle.
- R9: Stop variants 4 and 5 act only when bit 8 of the active config is clear. Variants 6 and 7 act only when that bit is set. A variant that does not act leaves the job running.
- R10: Writing 1 to the command register launches nothing and sets a sticky error flag, read as bit 0 at offset 9, which only reset clears.
- R11: Command register writes of 0 (no-op) or of 8 and above have no effect. The command register reads as zero.
- R12: A stop written while no job runs has no effect, either at once or on a later launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for one register write |
| wr_addr_i | input | 5 | Word offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Word offset of the read |
| rd_data_o | output | 32 | Combinational read data |
| exec_done_i | input | 1 | External execution model reports job end |
| exec_fault_i | input | 1 | Qualifies `exec_done_i` as a job fault |
| next_start_o | output | 1 | Staged command currently holds start |
| job_done_o | output | 1 | One-cycle job-done pulse to job control |
| job_fail_o | output | 1 | One-cycle job-failed pulse to job control |
| job_slot_o | output | SLOT_W | Slot tag during a done or failed pulse |

## Verification
Two exits can fall in the same cycle: a stop waiting to take effect, and a fault report from the execution model. The bench sets this up by issuing a hard stop to a running job and then raising `exec_done_i` and `exec_fault_i` in the very next cycle, which is the cycle in which the stop resolves. The result is judged at the ports. The status must read done and not the fault code, `job_done_o` must pulse and `job_fail_o` must stay low.

// File: rtl/job_slot_pkg.sv
package job_slot_pkg;

  localparam int DATA_W = 32;
  localparam int PTR_W  = 2 * DATA_W;
  localparam int ADDR_W = 5;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_START   = 3'd1,
    CMD_SOFT    = 3'd2,
    CMD_HARD    = 3'd3,
    CMD_SOFT_C0 = 3'd4,
    CMD_HARD_C0 = 3'd5,
    CMD_SOFT_C1 = 3'd6,
    CMD_HARD_C1 = 3'd7
  } cmd_e;

  localparam int NUM_CMDS = 8;

  // read-only active view
  localparam logic [ADDR_W-1:0] OFS_HEAD_LO = 5'd0;
  localparam logic [ADDR_W-1:0] OFS_HEAD_HI = 5'd1;
  localparam logic [ADDR_W-1:0] OFS_TAIL_LO = 5'd2;
  localparam logic [ADDR_W-1:0] OFS_TAIL_HI = 5'd3;
  localparam logic [ADDR_W-1:0] OFS_AFF_LO  = 5'd4;
  localparam logic [ADDR_W-1:0] OFS_AFF_HI  = 5'd5;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 5'd6;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'd7;
  localparam logic [ADDR_W-1:0] OFS_CMD     = 5'd8;
  localparam logic [ADDR_W-1:0] OFS_ERR     = 5'd9;

  // staging window
  localparam int STG_BASE    = 16;
  localparam int STG_COUNT   = 6;
  localparam int STG_HEAD_LO = 0;
  localparam int STG_HEAD_HI = 1;
  localparam int STG_AFF_LO  = 2;
  localparam int STG_AFF_HI  = 3;
  localparam int STG_CFG     = 4;
  localparam int STG_CMD     = 5;
  localparam logic [ADDR_W-1:0] OFS_STG_CMD = ADDR_W'(STG_BASE + STG_CMD);

  // staging entries wiped by a launch: head halves and staged command
  localparam logic [STG_COUNT-1:0] STG_CLEAR_MASK = 6'b100011;

  localparam int CHAIN_BIT = 8;

  // status codes, class field in bits 7:6 (00 no fault, 01 job fault)
  localparam word_t ST_IDLE   = 32'h0000_0000;
  localparam word_t ST_DONE   = 32'h0000_0001;
  localparam word_t ST_ACTIVE = 32'h0000_0008;
  localparam word_t ST_FAULT  = 32'h0000_0040;

  function automatic logic cmd_in_range(word_t v);
    return v < word_t'(NUM_CMDS);
  endfunction

  function automatic logic stop_applies(word_t v, logic chain);
    logic ok;
    ok = 1'b0;
    if (cmd_in_range(v)) begin
      case (cmd_e'(v[2:0]))
        CMD_SOFT, CMD_HARD:       ok = 1'b1;
        CMD_SOFT_C0, CMD_HARD_C0: ok = !chain;
        CMD_SOFT_C1, CMD_HARD_C1: ok = chain;
        default:                  ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  function automatic word_t exit_status(logic stopped, logic faulted);
    if (stopped) return ST_DONE;
    return faulted ? ST_FAULT : ST_DONE;
  endfunction

  function automatic logic status_is_fault(word_t s);
    return s[7:6] == 2'b01;
  endfunction

endpackage

// File: rtl/job_slot_stage.sv
module job_slot_stage
  import job_slot_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  word_t                        wr_data_i,
  output logic                         launch_o,
  output word_t [STG_COUNT-1:0]        stg_o
);

  for (genvar g = 0; g < STG_COUNT; g++) begin : g_stg
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(STG_BASE + g);
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == MY_OFS);

    // a write in the launch cycle wins over the launch clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             stg_o[g] <= '0;
      else if (hit)                            stg_o[g] <= wr_data_i;
      else if (launch_o && STG_CLEAR_MASK[g])  stg_o[g] <= '0;
    end
  end

  assign launch_o = (stg_o[STG_CMD] == word_t'(CMD_START));

endmodule

// File: rtl/job_slot_cmd.sv
module job_slot_cmd
  import job_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  word_t             wr_data_i,
  input  logic              chain_i,
  input  logic              running_i,
  output logic              stop_hit_o,
  output logic              err_flag_o
);

  logic cmd_wr;
  logic illegal_start;

  assign cmd_wr        = wr_en_i && (wr_addr_i == OFS_CMD);
  assign illegal_start = cmd_wr && (wr_data_i == word_t'(CMD_START));
  assign stop_hit_o    = cmd_wr && running_i && stop_applies(wr_data_i, chain_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            err_flag_o <= 1'b0;
    else if (illegal_start) err_flag_o <= 1'b1;
  end

endmodule

// File: rtl/job_slot_exec.sv
module job_slot_exec
  import job_slot_pkg::*;
#(
  parameter bit AUTO_FINISH = 1'b1,
  parameter int SLOT_W      = 4,
  parameter int SLOT_ID     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [PTR_W-1:0]  stg_head_i,
  input  logic [PTR_W-1:0]  stg_aff_i,
  input  word_t             stg_cfg_i,
  input  logic              stop_hit_i,
  input  logic              exec_done_i,
  input  logic              exec_fault_i,
  output logic [PTR_W-1:0]  act_head_o,
  output logic [PTR_W-1:0]  act_tail_o,
  output logic [PTR_W-1:0]  act_aff_o,
  output word_t             act_cfg_o,
  output word_t             status_o,
  output logic              running_o,
  output logic              stop_pend_o,
  output logic              job_done_o,
  output logic              job_fail_o,
  output logic [SLOT_W-1:0] job_slot_o
);

  logic  finish;
  logic  fault_exit;
  word_t exit_code;

  assign fault_exit = exec_done_i && exec_fault_i;
  assign finish     = running_o && !launch_i &&
                      (stop_pend_o || AUTO_FINISH || exec_done_i);
  assign exit_code  = exit_status(stop_pend_o, fault_exit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_head_o  <= '0;
      act_tail_o  <= '0;
      act_aff_o   <= '0;
      act_cfg_o   <= '0;
      status_o    <= ST_IDLE;
      running_o   <= 1'b0;
      stop_pend_o <= 1'b0;
      job_done_o  <= 1'b0;
      job_fail_o  <= 1'b0;
      job_slot_o  <= '0;
    end else begin
      job_done_o <= 1'b0;
      job_fail_o <= 1'b0;
      job_slot_o <= '0;
      if (launch_i) begin
        act_head_o  <= stg_head_i;
        act_tail_o  <= stg_head_i;
        act_aff_o   <= stg_aff_i;
        act_cfg_o   <= stg_cfg_i;
        status_o    <= ST_ACTIVE;
        running_o   <= 1'b1;
        stop_pend_o <= 1'b0;
      end else if (finish) begin
        status_o    <= exit_code;
        running_o   <= 1'b0;
        stop_pend_o <= 1'b0;
        job_done_o  <= !status_is_fault(exit_code);
        job_fail_o  <= status_is_fault(exit_code);
        job_slot_o  <= SLOT_W'(SLOT_ID);
      end else if (stop_hit_i) begin
        stop_pend_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/job_slot_ctrl.sv
module job_slot_ctrl
  import job_slot_pkg::*;
#(
  parameter bit AUTO_FINISH = 1'b1,
  parameter int SLOT_W      = 4,
  parameter int SLOT_ID     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [4:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              exec_done_i,
  input  logic              exec_fault_i,
  output logic              next_start_o,
  output logic              job_done_o,
  output logic              job_fail_o,
  output logic [SLOT_W-1:0] job_slot_o
);

  word_t [STG_COUNT-1:0] stg;
  logic  [PTR_W-1:0]     stg_head;
  logic  [PTR_W-1:0]     stg_aff;
  logic  [PTR_W-1:0]     act_head;
  logic  [PTR_W-1:0]     act_tail;
  logic  [PTR_W-1:0]     act_aff;
  word_t                 act_cfg;
  word_t                 status;
  logic                  launch;
  logic                  stop_hit;
  logic                  running;
  logic                  stop_pend;
  logic                  err_flag;

  assign stg_head     = {stg[STG_HEAD_HI], stg[STG_HEAD_LO]};
  assign stg_aff      = {stg[STG_AFF_HI], stg[STG_AFF_LO]};
  assign next_start_o = launch;

  job_slot_stage u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .launch_o  (launch),
    .stg_o     (stg)
  );

  job_slot_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .chain_i    (act_cfg[CHAIN_BIT]),
    .running_i  (running),
    .stop_hit_o (stop_hit),
    .err_flag_o (err_flag)
  );

  job_slot_exec #(
    .AUTO_FINISH (AUTO_FINISH),
    .SLOT_W      (SLOT_W),
    .SLOT_ID     (SLOT_ID)
  ) u_exec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .stg_head_i   (stg_head),
    .stg_aff_i    (stg_aff),
    .stg_cfg_i    (stg[STG_CFG]),
    .stop_hit_i   (stop_hit),
    .exec_done_i  (exec_done_i),
    .exec_fault_i (exec_fault_i),
    .act_head_o   (act_head),
    .act_tail_o   (act_tail),
    .act_aff_o    (act_aff),
    .act_cfg_o    (act_cfg),
    .status_o     (status),
    .running_o    (running),
    .stop_pend_o  (stop_pend),
    .job_done_o   (job_done_o),
    .job_fail_o   (job_fail_o),
    .job_slot_o   (job_slot_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFS_HEAD_LO: rd_data_o = act_head[DATA_W-1:0];
      OFS_HEAD_HI: rd_data_o = act_head[PTR_W-1:DATA_W];
      OFS_TAIL_LO: rd_data_o = act_tail[DATA_W-1:0];
      OFS_TAIL_HI: rd_data_o = act_tail[PTR_W-1:DATA_W];
      OFS_AFF_LO:  rd_data_o = act_aff[DATA_W-1:0];
      OFS_AFF_HI:  rd_data_o = act_aff[PTR_W-1:DATA_W];
      OFS_CFG:     rd_data_o = act_cfg;
      OFS_STATUS:  rd_data_o = status;
      OFS_ERR:     rd_data_o = {{(DATA_W-1){1'b0}}, err_flag};
      default: begin
        for (int i = 0; i < STG_COUNT; i++) begin
          if (rd_addr_i == ADDR_W'(STG_BASE + i)) rd_data_o = stg[i];
        end
      end
    endcase
  end

endmodule

// File: rtl/job_slot_ctrl_chk.sv
module job_slot_ctrl_chk
  import job_slot_pkg::*;
#(
  parameter bit AUTO_FINISH = 1'b1,
  parameter int SLOT_W      = 4,
  parameter int SLOT_ID     = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [4:0]        wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic              launch,
  input logic              running,
  input logic              stop_pend,
  input logic              err_flag,
  input logic [31:0]       status,
  input logic [PTR_W-1:0]  stg_head,
  input logic [PTR_W-1:0]  act_head,
  input logic [PTR_W-1:0]  act_tail,
  input logic              next_start_o,
  input logic              job_done_o,
  input logic              job_fail_o,
  input logic [SLOT_W-1:0] job_slot_o
);

  logic stg_cmd_wr;
  assign stg_cmd_wr = wr_en_i && (wr_addr_i == OFS_STG_CMD);

  p_launch_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (status == ST_ACTIVE) && (act_head == $past(stg_head)) &&
               (act_tail == $past(stg_head)));

  p_cmd_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch && !stg_cmd_wr |=> !next_start_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_done_o |=> !job_done_o);

  p_slot_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_slot_o == ((job_done_o || job_fail_o) ? SLOT_W'(SLOT_ID) : '0));

  if (AUTO_FINISH) begin : g_auto
    p_auto_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      launch && !stg_cmd_wr |=> ##1 job_done_o);
  end

  p_done_fail_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(job_done_o && job_fail_o));

  p_stop_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && stop_pend && !launch |=> job_done_o && (status == ST_DONE));

  p_illegal_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i == OFS_CMD) && (wr_data_i == 32'd1) |=> err_flag);

  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag |=> err_flag);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> !job_done_o && !job_fail_o);

endmodule

bind job_slot_ctrl job_slot_ctrl_chk #(
  .AUTO_FINISH (AUTO_FINISH),
  .SLOT_W      (SLOT_W),
  .SLOT_ID     (SLOT_ID)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .launch       (launch),
  .running      (running),
  .stop_pend    (stop_pend),
  .err_flag     (err_flag),
  .status       (status),
  .stg_head     (stg_head),
  .act_head     (act_head),
  .act_tail     (act_tail),
  .next_start_o (next_start_o),
  .job_done_o   (job_done_o),
  .job_fail_o   (job_fail_o),
  .job_slot_o   (job_slot_o)
);

// File: tb/job_slot_ctrl_tb.sv
`timescale 1ns/1ps
module job_slot_ctrl_tb;

  typedef struct packed {
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] exp;
  } vec_t;

  // write, then read back one offset
  localparam vec_t VECS [0:11] = '{
    '{5'd16, 32'h1000_0040, 5'd16, 32'h1000_0040}, // R2 head lo
    '{5'd17, 32'h0000_00AB, 5'd17, 32'h0000_00AB}, // R2 head hi
    '{5'd18, 32'h0000_000F, 5'd18, 32'h0000_000F}, // R2 affinity lo
    '{5'd19, 32'h0000_0001, 5'd19, 32'h0000_0001}, // R2 affinity hi
    '{5'd20, 32'h0000_0000, 5'd20, 32'h0000_0000}, // R2 config, chain clear
    '{5'd7,  32'hFFFF_FFFF, 5'd7,  32'h0000_0000}, // R2 status read-only
    '{5'd0,  32'h0000_1234, 5'd0,  32'h0000_0000}, // R2 active head read-only
    '{5'd9,  32'h0000_0001, 5'd9,  32'h0000_0000}, // R2 error flag read-only
    '{5'd30, 32'h0000_0005, 5'd30, 32'h0000_0000}, // R2 unmapped
    '{5'd8,  32'h0000_0000, 5'd8,  32'h0000_0000}, // R11 no-op, reads zero
    '{5'd8,  32'h0000_0009, 5'd9,  32'h0000_0000}, // R11 out-of-range code
    '{5'd21, 32'h0000_0002, 5'd21, 32'h0000_0002}  // R3 non-start stays staged
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data_a;
  logic        exec_done = 1'b0, exec_fault = 1'b0;
  logic        nxt, done, fail, nxt_a, done_a, fail_a;
  logic [3:0]  slot, slot_a;
  logic        zero = 1'b0;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  job_slot_ctrl #(.AUTO_FINISH(1'b0), .SLOT_W(4), .SLOT_ID(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .exec_done_i(exec_done), .exec_fault_i(exec_fault),
    .next_start_o(nxt), .job_done_o(done), .job_fail_o(fail), .job_slot_o(slot));

  job_slot_ctrl #(.AUTO_FINISH(1'b1), .SLOT_W(4), .SLOT_ID(3)) u_auto (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data_a),
    .exec_done_i(zero), .exec_fault_i(zero),
    .next_start_o(nxt_a), .job_done_o(done_a), .job_fail_o(fail_a), .job_slot_o(slot_a));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    rd_addr = a;
    #0.1;
    chk(tag, rd_data, exp);
  endtask

  task automatic chk_reg_a(input string tag, input logic [4:0] a, input logic [31:0] exp);
    rd_addr = a;
    #0.1;
    chk(tag, rd_data_a, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_end(input logic flt);
    exec_done = 1'b1; exec_fault = flt;
    @(negedge clk);
    exec_done = 1'b0; exec_fault = 1'b0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 10; a++) chk_reg("R1 active view zero", 5'(a), 32'h0);
    for (int a = 16; a < 22; a++) chk_reg("R1 staging zero", 5'(a), 32'h0);
    chk("R1 outputs low", {28'h0, nxt, done, fail, |slot}, 32'h0);

    // R2 R3 R11: table of writes and readbacks
    for (int i = 0; i < 12; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      chk_reg($sformatf("R2/R3/R11 vector %0d", i), VECS[i].ra, VECS[i].exp);
    end
    chk("R3 non-start gives no next-start", {31'h0, nxt}, 32'h0);
    chk_reg("R3 no launch from non-start", 5'd7, 32'h0);

    // R4 R5 R6: launch both slots
    wr(5'd21, 32'd1);
    chk("R3 next-start high while staged", {31'h0, nxt}, 32'h1);
    @(negedge clk);
    chk_reg("R4 status active", 5'd7, 32'h08);
    chk_reg("R4 head lo", 5'd0, 32'h1000_0040);
    chk_reg("R4 head hi", 5'd1, 32'h0000_00AB);
    chk_reg("R4 tail lo", 5'd2, 32'h1000_0040);
    chk_reg("R4 tail hi", 5'd3, 32'h0000_00AB);
    chk_reg("R4 affinity lo", 5'd4, 32'h0000_000F);
    chk_reg("R4 affinity hi", 5'd5, 32'h0000_0001);
    chk_reg("R5 staged head lo cleared", 5'd16, 32'h0);
    chk_reg("R5 staged head hi cleared", 5'd17, 32'h0);
    chk_reg("R5 staged cmd cleared", 5'd21, 32'h0);
    chk_reg("R5 staged affinity kept", 5'd18, 32'h0000_000F);
    chk_reg("R5 staged affinity hi kept", 5'd19, 32'h0000_0001);
    chk("R6 no done in active cycle", {31'h0, done_a}, 32'h0);
    @(negedge clk);
    chk_reg_a("R6 auto status done", 5'd7, 32'h01);
    chk("R6 auto done pulse", {31'h0, done_a}, 32'h1);
    chk("R6 auto slot tag", {28'h0, slot_a}, 32'h3);
    chk_reg("R7 external slot still active", 5'd7, 32'h08);
    @(negedge clk);
    chk("R6 pulse lasts one cycle", {31'h0, done_a}, 32'h0);
    chk("R6 slot tag cleared", {28'h0, slot_a}, 32'h0);

    // R7: external completion, no fault
    ext_end(1'b0);
    chk_reg("R7 status done", 5'd7, 32'h01);
    chk("R7 done pulse", {30'h0, done, fail}, 32'h2);
    chk("R7 slot tag", {28'h0, slot}, 32'h1);

    // R7: external completion with fault
    wr(5'd21, 32'd1);
    @(negedge clk);
    ext_end(1'b1);
    chk_reg("R7 status fault", 5'd7, 32'h40);
    chk("R7 fail pulse", {30'h0, done, fail}, 32'h1);

    // R8: stop resolves in the cycle a fault arrives
    wr(5'd21, 32'd1);
    @(negedge clk);
    wr(5'd8, 32'd3);
    chk_reg("R8 still active after stop write", 5'd7, 32'h08);
    ext_end(1'b1);
    chk_reg("R8 stop gives done", 5'd7, 32'h01);
    chk("R8 done not fail", {30'h0, done, fail}, 32'h2);

    // R9: chain flag clear
    wr(5'd21, 32'd1);
    @(negedge clk);
    wr(5'd8, 32'd6);
    @(negedge clk);
    chk_reg("R9 variant 6 ignored with chain clear", 5'd7, 32'h08);
    chk("R9 no pulse", {30'h0, done, fail}, 32'h0);
    wr(5'd8, 32'd4);
    @(negedge clk);
    chk_reg("R9 variant 4 acts with chain clear", 5'd7, 32'h01);

    // R9: chain flag set
    wr(5'd20, 32'h0000_0100);
    wr(5'd21, 32'd1);
    @(negedge clk);
    chk_reg("R4 config copied", 5'd6, 32'h0000_0100);
    wr(5'd8, 32'd5);
    @(negedge clk);
    chk_reg("R9 variant 5 ignored with chain set", 5'd7, 32'h08);
    wr(5'd8, 32'd7);
    @(negedge clk);
    chk_reg("R9 variant 7 acts with chain set", 5'd7, 32'h01);

    // R10: start through the command register
    wr(5'd8, 32'd1);
    chk_reg("R10 error flag set", 5'd9, 32'h1);
    chk("R10 no next-start", {31'h0, nxt}, 32'h0);
    @(negedge clk);
    chk_reg("R10 no launch", 5'd7, 32'h01);
    wr(5'd8, 32'd0);
    chk_reg("R10 flag sticky", 5'd9, 32'h1);

    // R12: stop while idle, then launch
    wr(5'd8, 32'd2);
    @(negedge clk);
    chk_reg("R12 idle stop no effect", 5'd7, 32'h01);
    chk("R12 no pulse", {30'h0, done, fail}, 32'h0);
    wr(5'd21, 32'd1);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk_reg("R12 no stale stop after launch", 5'd7, 32'h08);
    ext_end(1'b0);
    chk_reg("R7 final done", 5'd7, 32'h01);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule